// File: doc/BRIEF.md
# SPI Transmit Zero-Word Pump

This block sits beside the transmit FIFO of an SPI controller. Software programs a byte count, and the block pushes 32-bit words of zeros into the transmit FIFO for it. Every zero byte shifted out clocks one byte of the slave's reply into the receive FIFO, so a long read needs no per-word transmit writes from software. The block watches the occupancy of both FIFOs. It never queues more zero words than the receive FIFO can absorb.

Register writes reach the block on a simple write port. Three registers matter here: a configuration register that holds a manual-start enable bit and accepts a manual-start command bit, a command register that holds a push-wait bit, and the byte-count register. The block asks the shifter to run a pass in two cases: a manual start has been latched, or the transmit FIFO holds data while manual mode is off. Zero words are pushed only during such a pass. A push happens only when the count is nonzero, the push-wait hold is not in force, and the receive guard leaves room.

Top module: `zp_ctrl`

## Requirements
- R1: After reset, `push_zero` and `flush_req` are 0 and `size_left` is 0. The manual-start enable bit, the push-wait bit and the latched start flag are all clear.
- R2: While `size_left` is 0, no zero word is pushed.
- R3: While the push-wait bit (bit 0 of the command register at byte offset 0xC0) is set and `tx_level` is nonzero, no zero word is pushed.
- R4: A zero word is pushed only in a cycle where `rx_level + tx_level + 3 < RX_AFULL`. The default `RX_AFULL` is 64. With the receive FIFO empty, pumping therefore stalls once the transmit FIFO holds 64 bytes.
- R5: On each push, `size_left` changes on the next clock edge. The new value is the old value rounded down to a multiple of 4, then reduced by 4, and never goes below 0. A count of 1 to 7 takes one push to reach 0. A count of 10 takes two. Without a push or a write, `size_left` holds its value.
- R6: A write to the configuration register (byte offset 0x00) with the command bit (bit 16) set latches the start flag only if the enable bit (bit 15) was already set before that write. The command bit is not stored: a later write without it starts nothing.
- R7: `flush_req` is 1 when the start flag is set, or when `tx_level` is nonzero and the enable bit is clear. Pushes happen only while `flush_req` is 1.
- R8: The start flag clears on the edge after a cycle in which `tx_level` is 0, `size_left` is 0 and no new start is latched. A start latched with both already 0 raises `flush_req` for exactly one cycle.
- R9: A write to the byte-count register (byte offset 0xC4) loads `size_left` with the written value on the next edge. This holds even if a push happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Byte offset of the register write |
| wr_data | input | 32 | Register write data |
| tx_level | input | clog2(FIFO_BYTES+1) (8) | Bytes held in the transmit FIFO |
| rx_level | input | clog2(FIFO_BYTES+1) (8) | Bytes held in the receive FIFO |
| push_zero | output | 1 | Push one 32-bit zero word into the transmit FIFO this cycle |
| flush_req | output | 1 | Ask the shifter to drain the transmit FIFO |
| size_left | output | 32 | Bytes still to be zero-pumped |

## Verification
Two events can land in the same cycle: a software write of a new byte count and the decrement caused by a push. The bench starts a long pump with the receive FIFO empty and the shifter draining, so a push happens every cycle. It then writes a short count in the middle of that run. The bench expects the written count to appear on the next edge, with the concurrent push dropped from the arithmetic. A second collision is also provoked: a manual start issued while the transmit FIFO and the count are both already zero. For that case `flush_req` must rise for exactly one cycle.

// File: rtl/zp_pkg.sv
package zp_pkg;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned RX_GUARD   = 3;

  // Count after one zero word: align down to a word, take one word off, floor at zero.
  function automatic logic [31:0] zp_next_size(input logic [31:0] cur);
    logic [31:0] aligned;
    aligned = cur & ~32'(WORD_BYTES - 1);
    if (aligned >= 32'(WORD_BYTES)) return aligned - 32'(WORD_BYTES);
    return '0;
  endfunction

  // Room for one more word without letting the receive side overflow.
  function automatic logic zp_has_room(input logic [31:0] rx,
                                       input logic [31:0] tx,
                                       input logic [31:0] afull);
    return (rx + tx + 32'(RX_GUARD)) < afull;
  endfunction

endpackage

// File: rtl/zp_regs.sv
module zp_regs #(
  parameter int ADDR_W   = 8,
  parameter int CFG_OFS  = 'h00,
  parameter int CMD_OFS  = 'hC0,
  parameter int SIZE_OFS = 'hC4,
  parameter int MSE_BIT  = 15,
  parameter int MSC_BIT  = 16,
  parameter int WAIT_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              mse_q,
  output logic              wait_q,
  output logic              size_wr,
  output logic [31:0]       size_val,
  output logic              start_req
);

  logic cfg_hit;
  logic cmd_hit;

  always_comb begin
    cfg_hit   = wr_en && (wr_addr == ADDR_W'(CFG_OFS));
    cmd_hit   = wr_en && (wr_addr == ADDR_W'(CMD_OFS));
    size_wr   = wr_en && (wr_addr == ADDR_W'(SIZE_OFS));
    size_val  = wr_data;
    // only an enable already in force arms the start; the command bit is never kept
    start_req = cfg_hit && wr_data[MSC_BIT] && mse_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mse_q  <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      if (cfg_hit) mse_q  <= wr_data[MSE_BIT];
      if (cmd_hit) wait_q <= wr_data[WAIT_BIT];
    end
  end

endmodule

// File: rtl/zp_start_latch.sv
module zp_start_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic tx_empty,
  input  logic size_zero,
  output logic start_flag,
  output logic clr_evt
);

  always_comb clr_evt = start_flag && tx_empty && size_zero && !set_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       start_flag <= 1'b0;
    else if (set_req) start_flag <= 1'b1;
    else if (clr_evt) start_flag <= 1'b0;
  end

endmodule

// File: rtl/zp_pump.sv
module zp_pump
  import zp_pkg::*;
#(
  parameter int LVL_W    = 8,
  parameter int RX_AFULL = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_flag,
  input  logic             mse_q,
  input  logic             wait_q,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             size_wr,
  input  logic [31:0]      size_val,
  output logic [31:0]      size_q,
  output logic             pass_on,
  output logic             push_zero
);

  logic tx_busy;
  logic held;
  logic room_ok;

  always_comb begin
    tx_busy   = (tx_level != '0);
    pass_on   = start_flag || (tx_busy && !mse_q);
    held      = tx_busy && wait_q;
    room_ok   = zp_has_room(32'(rx_level), 32'(tx_level), 32'(RX_AFULL));
    push_zero = pass_on && (size_q != '0) && !held && room_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         size_q <= '0;
    else if (size_wr)   size_q <= size_val;
    else if (push_zero) size_q <= zp_next_size(size_q);
  end

endmodule

// File: rtl/zp_ctrl.sv
module zp_ctrl #(
  parameter int FIFO_BYTES = 128,
  parameter int RX_AFULL   = 64,
  parameter int ADDR_W     = 8,
  parameter int CFG_OFS    = 'h00,
  parameter int CMD_OFS    = 'hC0,
  parameter int SIZE_OFS   = 'hC4,
  parameter int MSE_BIT    = 15,
  parameter int MSC_BIT    = 16,
  parameter int WAIT_BIT   = 0,
  localparam int LVL_W     = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  output logic              push_zero,
  output logic              flush_req,
  output logic [31:0]       size_left
);

  // named internal events, also watched by the bound checker
  logic        mse_q;
  logic        wait_q;
  logic        size_wr;
  logic [31:0] size_val;
  logic        start_req;
  logic        start_flag;
  logic        clr_evt;
  logic        tx_empty;
  logic        size_zero;

  always_comb begin
    tx_empty  = (tx_level == '0);
    size_zero = (size_left == '0);
  end

  zp_regs #(
    .ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .CMD_OFS(CMD_OFS), .SIZE_OFS(SIZE_OFS),
    .MSE_BIT(MSE_BIT), .MSC_BIT(MSC_BIT), .WAIT_BIT(WAIT_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mse_q(mse_q), .wait_q(wait_q), .size_wr(size_wr), .size_val(size_val),
    .start_req(start_req)
  );

  zp_start_latch u_start (
    .clk(clk), .rst_n(rst_n), .set_req(start_req), .tx_empty(tx_empty),
    .size_zero(size_zero), .start_flag(start_flag), .clr_evt(clr_evt)
  );

  zp_pump #(.LVL_W(LVL_W), .RX_AFULL(RX_AFULL)) u_pump (
    .clk(clk), .rst_n(rst_n), .start_flag(start_flag), .mse_q(mse_q), .wait_q(wait_q),
    .tx_level(tx_level), .rx_level(rx_level), .size_wr(size_wr), .size_val(size_val),
    .size_q(size_left), .pass_on(flush_req), .push_zero(push_zero)
  );

endmodule

// File: rtl/zp_ctrl_chk.sv
module zp_ctrl_chk #(
  parameter int LVL_W    = 8,
  parameter int RX_AFULL = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_zero,
  input logic             flush_req,
  input logic [31:0]      size_left,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             wait_q,
  input logic             size_wr,
  input logic [31:0]      size_val,
  input logic             start_req,
  input logic             start_flag,
  input logic             clr_evt
);

  AST_NO_EMPTY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_zero |-> (size_left != 32'd0)); // R2
  AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && (tx_level != '0)) |-> !push_zero); // R3
  AST_RX_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push_zero |-> ((int'(rx_level) + int'(tx_level) + 3) < RX_AFULL)); // R4
  AST_SIZE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_zero && !size_wr) |=> ((size_left < $past(size_left)) && (size_left[1:0] == 2'b00))); // R5
  AST_SIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_zero && !size_wr) |=> $stable(size_left)); // R5
  AST_START_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> start_flag); // R6
  AST_PASS_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    push_zero |-> flush_req); // R7
  AST_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !start_flag); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    size_wr |=> (size_left == $past(size_val))); // R9

endmodule

bind zp_ctrl zp_ctrl_chk #(.LVL_W(LVL_W), .RX_AFULL(RX_AFULL)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_zero(push_zero), .flush_req(flush_req),
  .size_left(size_left), .tx_level(tx_level), .rx_level(rx_level), .wait_q(wait_q),
  .size_wr(size_wr), .size_val(size_val), .start_req(start_req),
  .start_flag(start_flag), .clr_evt(clr_evt)
);

// File: tb/sim_zp_ctrl.sv
`timescale 1ns/1ps
module sim_zp_ctrl;

  localparam int RX_AFULL = 64;
  localparam int LVL_W    = 8;
  localparam logic [7:0] A_CFG  = 8'h00;
  localparam logic [7:0] A_CMD  = 8'hC0;
  localparam logic [7:0] A_SIZE = 8'hC4;
  localparam logic [31:0] D_EN    = 32'h0000_8000;
  localparam logic [31:0] D_CMD   = 32'h0001_0000;
  localparam logic [31:0] D_START = 32'h0001_8000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_addr = '0;
  logic [31:0]      wr_data = '0;
  logic [LVL_W-1:0] tx_level;
  logic [LVL_W-1:0] rx_level;
  logic             push_zero;
  logic             flush_req;
  logic [31:0]      size_left;

  int tx = 0;
  int rx = 0;
  bit drain = 1'b0;
  int push_cnt = 0;
  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference state
  bit m_en = 0, m_wait = 0, m_flag = 0;
  longint m_size = 0;

  assign tx_level = LVL_W'(tx);
  assign rx_level = LVL_W'(rx);

  always #10 clk = ~clk;

  zp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_level(tx_level), .rx_level(rx_level), .push_zero(push_zero),
    .flush_req(flush_req), .size_left(size_left)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock: compare at the falling edge, advance the model and the FIFO levels after the rise
  task automatic tick();
    bit e_pass, e_push, set;
    bit n_en, n_wait, n_flag;
    longint n_size, al;
    @(negedge clk);
    e_pass = m_flag || (tx != 0 && !m_en);
    e_push = e_pass && m_size != 0 && !(tx != 0 && m_wait) && (rx + tx < RX_AFULL - 3);
    chk("R7", "flush_req", flush_req, e_pass);
    chk("R4", "push_zero", push_zero, e_push);
    chk("R5", "size_left", size_left, m_size);
    n_en = m_en; n_wait = m_wait; n_size = m_size; n_flag = m_flag; set = 0;
    if (wr_en && wr_addr == A_CFG) begin n_en = wr_data[15]; set = wr_data[16] && m_en; end
    if (wr_en && wr_addr == A_CMD) n_wait = wr_data[0];
    if (wr_en && wr_addr == A_SIZE) n_size = wr_data;
    else if (e_push) begin
      al = (m_size / 4) * 4;
      n_size = (al >= 4) ? al - 4 : 0;
    end
    if (set) n_flag = 1;
    else if (m_flag && tx == 0 && m_size == 0) n_flag = 0;
    @(posedge clk);
    #1;
    m_en = n_en; m_wait = n_wait; m_size = n_size; m_flag = n_flag;
    if (drain && tx >= 4) tx -= 4;
    if (e_push) begin tx += 4; push_cnt++; end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "push_zero in reset", push_zero, 0);
    chk("R1", "flush_req in reset", flush_req, 0);
    chk("R1", "size_left in reset", size_left, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // automatic mode: a pass needs transmit data
    wr(A_SIZE, 16);
    run(3);
    chk("R7", "no pass with empty tx in auto mode", flush_req, 0);
    base = push_cnt;
    tx = 8; #1;
    chk("R7", "pass with tx data in auto mode", flush_req, 1);
    run(8);
    chk("R5", "pushes for 16 bytes", push_cnt - base, 4);
    chk("R5", "count after 16 bytes", size_left, 0);
    base = push_cnt;
    run(5);
    chk("R2", "no push at zero count", push_cnt - base, 0);

    // push-wait hold
    tx = 0;
    wr(A_CMD, 1);
    tx = 8;
    wr(A_SIZE, 20);
    base = push_cnt;
    run(4);
    chk("R3", "held while tx busy", push_cnt - base, 0);
    wr(A_CMD, 0);
    run(8);
    chk("R3", "pushes after wait released", push_cnt - base, 5);
    tx = 0;
    run(2);

    // manual start arming and the receive guard
    wr(A_SIZE, 400);
    wr(A_CFG, D_CMD);
    base = push_cnt;
    run(3);
    chk("R6", "command without enable", push_cnt - base, 0);
    wr(A_CFG, D_EN);
    wr(A_CFG, D_START);
    run(30);
    chk("R4", "pushes before guard", push_cnt - base, 16);
    chk("R4", "tx level at guard", tx, 64);
    chk("R5", "count at guard", size_left, 336);
    drain = 1'b1;
    run(120);
    chk("R5", "total pushes for 400 bytes", push_cnt - base, 100);
    chk("R8", "flag dropped after drain", flush_req, 0);
    wr(A_SIZE, 8);
    wr(A_CFG, D_EN);
    base = push_cnt;
    run(4);
    chk("R6", "command bit not kept", push_cnt - base, 0);
    wr(A_CFG, D_START);
    run(20);
    chk("R6", "restart pumps 8 bytes", push_cnt - base, 2);

    // guard boundary
    drain = 1'b0; tx = 0; rx = 57;
    wr(A_SIZE, 40);
    base = push_cnt;
    wr(A_CFG, D_START);
    run(6);
    chk("R4", "one push at boundary", push_cnt - base, 1);
    chk("R4", "count at boundary", size_left, 36);
    rx = 0; drain = 1'b1;
    run(40);

    // residual bytes
    wr(A_SIZE, 6);
    base = push_cnt;
    wr(A_CFG, D_START);
    run(6);
    chk("R5", "6 bytes take one push", push_cnt - base, 1);
    wr(A_SIZE, 2);
    base = push_cnt;
    wr(A_CFG, D_START);
    run(6);
    chk("R5", "2 bytes take one push", push_cnt - base, 1);
    chk("R5", "count after residual", size_left, 0);

    // write collides with a push
    wr(A_SIZE, 200);
    wr(A_CFG, D_START);
    run(5);
    wr(A_SIZE, 12);
    chk("R9", "written count wins", size_left, 12);
    run(30);
    chk("R9", "count drained after rewrite", size_left, 0);

    // start latched with nothing to do
    chk("R8", "idle before start", flush_req, 0);
    wr(A_CFG, D_START);
    #1;
    chk("R8", "one-cycle pass raised", flush_req, 1);
    tick();
    #1;
    chk("R8", "one-cycle pass dropped", flush_req, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

endmodule